// File: doc/BRIEF.md
# Interrupt Flag and Clear Unit

This block holds the event flags of one group of a timed digital input engine and turns them into one interrupt request. Four events are sticky: the transfer count running out, a handshake wait timeout, and the primary and secondary terminal counts. Each latches on a one-cycle event pulse. A fifth bit, transfer ready, is a live copy of the data FIFO's not-empty level. A host-written enable byte with the same bit layout masks the flags. A small master control register gates the masked result onto the interrupt output and also picks the interrupt line and the output style.

The host clears flags by writing ones to two write-only clear registers. The first one clears the wait, primary and secondary flags and also carries one-cycle FIFO and DMA reset strobes. The second one clears only the count-expired flag. A transfer count register, written a byte at a time before a run, is decremented by each completed transfer. The transfer that takes it from one to zero raises count expired. A status byte reports pending enabled work together with the request and stop trigger lines.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset the flags, enable byte, master control and transfer count read zero, the interrupt output is low and both reset strobes are low.
- R2: Flag byte (read address 0) bits: 1 count expired, 5 waited, 6 primary terminal count, 7 secondary terminal count. Each sets on the clock edge that samples its event pulse and holds until cleared. Bits 2 to 4 read zero.
- R3: Flag bit 0 (transfer ready) equals the FIFO not-empty input in the same cycle and has no clear bit.
- R4: A write to address 0 (first clear register) clears waited with data bit 3, primary terminal count with bit 4 and secondary terminal count with bit 5. Writing 0xF8 clears all three. This register never changes count expired.
- R5: A write to address 1 (second clear register) with data bit 0 set clears count expired and no other flag.
- R6: When a flag's event and its clear arrive in the same cycle, the flag ends up set.
- R7: First clear register data bit 6 makes the DMA reset output high and bit 7 makes the FIFO reset output high, each for exactly the one cycle after the write edge.
- R8: The enable register at address 2 uses the flag bit layout. Only bits 0, 1, 5, 6 and 7 are stored. The other bits read zero.
- R9: Master control at address 3 stores bits [2:0]. Bits [1:0] drive the line-select output and bit 2 drives the open-output select. The interrupt is high exactly when some flag AND enable bit is set and bits [1:0] are nonzero. Writing 0x00 silences it.
- R10: Status at address 1 reads: bit 0 = OR of the enabled flags, bit 2 = request line input, bit 3 = stop trigger input. All other bits are zero.
- R11: The transfer count sits at addresses 4 to 7, least significant byte first. A transfer pulse decrements a nonzero count. The pulse that moves it from 1 to 0 sets count expired. Pulses at zero do nothing. A byte write in the same cycle overrides the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | ADDR_W | Host write address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | ADDR_W | Host read address |
| host_rdata | output | 8 | Host read data (combinational) |
| fifo_not_empty | input | 1 | Data FIFO holds a word |
| xfer_pulse | input | 1 | One transfer completed |
| wait_timeout | input | 1 | Handshake wait timeout event |
| prim_tc | input | 1 | Primary terminal count event |
| sec_tc | input | 1 | Secondary terminal count event |
| req_line | input | 1 | Request line level |
| stop_trig | input | 1 | Stop trigger level |
| irq_req | output | 1 | Interrupt request |
| irq_line_sel | output | 2 | Selected interrupt line |
| irq_open_out | output | 1 | Open-output style select |
| fifo_reset | output | 1 | FIFO reset strobe |
| dma_reset | output | 1 | DMA reset strobe |

## Verification
The hardest case to reach is an event landing in the very cycle its clear is written, on a flag that is already enabled onto the interrupt. The other hard case is the last transfer arriving just as the host rewrites the count. The stimulus forces both collisions directly. A long random phase then biases count writes toward small values, so expiry, the clears of the two registers and collisions with the transfer pulses all recur. A behavioural reference model is compared on every cycle.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
   // flag / enable byte layout
   localparam int FB_XRDY = 0;
   localparam int FB_CEXP = 1;
   localparam int FB_WAIT = 5;
   localparam int FB_PTC  = 6;
   localparam int FB_STC  = 7;
   localparam logic [7:0] STICKY_MASK = 8'b1110_0010;
   localparam logic [7:0] FLAG_MASK   = 8'b1110_0011;
   // first clear register
   localparam int CA_WAIT = 3;
   localparam int CA_PTC  = 4;
   localparam int CA_STC  = 5;
   localparam int CA_DMA  = 6;
   localparam int CA_FIFO = 7;
   // second clear register
   localparam int CB_CEXP = 0;
   // status byte
   localparam int ST_LEFT = 0;
   localparam int ST_REQ  = 2;
   localparam int ST_STOP = 3;
   // address map
   localparam int A_FLAG_CLRA = 0;
   localparam int A_STAT_CLRB = 1;
   localparam int A_IEN       = 2;
   localparam int A_MCTL      = 3;
   localparam int A_CNT0      = 4;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_flag_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int CNT_BYTES = 4
) (
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   output logic                 clr_a_we,
   output logic                 clr_b_we,
   output logic                 ien_we,
   output logic                 mctl_we,
   output logic [CNT_BYTES-1:0] cnt_we
);
   assign clr_a_we = wr_en && (wr_addr == ADDR_W'(A_FLAG_CLRA));
   assign clr_b_we = wr_en && (wr_addr == ADDR_W'(A_STAT_CLRB));
   assign ien_we   = wr_en && (wr_addr == ADDR_W'(A_IEN));
   assign mctl_we  = wr_en && (wr_addr == ADDR_W'(A_MCTL));

   for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt_dec
      assign cnt_we[b] = wr_en && (wr_addr == ADDR_W'(A_CNT0 + b));
   end
endmodule

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // R6: set beats a simultaneous clear
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R2: a set flag stays set without a clear
   a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o);
   // R4 / R5: a lone clear drops the flag
   a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/irq_xfer_counter.sv
module irq_xfer_counter #(
   parameter int CNT_W = 32,
   localparam int CNT_BYTES = CNT_W / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CNT_BYTES-1:0] byte_we,
   input  logic [7:0]           wdata,
   input  logic                 xfer_i,
   output logic [CNT_W-1:0]     remain_o,
   output logic                 expire_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] rem_q, rem_nxt;
   logic             any_we;

   assign any_we = |byte_we;

   always_comb begin
      rem_nxt = rem_q;
      if (any_we) begin
         for (int b = 0; b < CNT_BYTES; b++)
            if (byte_we[b]) rem_nxt[b*8 +: 8] = wdata;
      end else if (xfer_i && (rem_q != '0)) begin
         rem_nxt = rem_q - ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rem_q <= '0;
      else        rem_q <= rem_nxt;
   end

   assign remain_o = rem_q;
   assign expire_o = xfer_i && !any_we && (rem_q == ONE);

   // R11: an idle zero count never wraps
   a_r11_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((rem_q == '0) && !any_we) |=> (rem_q == '0));
   // R11: expiry leaves the count at zero
   a_r11_expire_zero: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> (rem_q == '0));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
   import irq_flag_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int CNT_W       = 32,
   parameter bit REG_STROBES = 1'b1,
   localparam int CNT_BYTES  = CNT_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_waddr,
   input  logic [7:0]        host_wdata,
   input  logic [ADDR_W-1:0] host_raddr,
   output logic [7:0]        host_rdata,
   input  logic              fifo_not_empty,
   input  logic              xfer_pulse,
   input  logic              wait_timeout,
   input  logic              prim_tc,
   input  logic              sec_tc,
   input  logic              req_line,
   input  logic              stop_trig,
   output logic              irq_req,
   output logic [1:0]        irq_line_sel,
   output logic              irq_open_out,
   output logic              fifo_reset,
   output logic              dma_reset
);
   // elaboration checks
   if ((CNT_W % 8) != 0 || CNT_W < 8) begin : g_bad_cnt
      $error("CNT_W must be a nonzero multiple of 8");
   end
   if (A_CNT0 + CNT_BYTES > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the count bytes");
   end

   logic                 clr_a_we, clr_b_we, ien_we, mctl_we;
   logic [CNT_BYTES-1:0] cnt_we;
   logic [CNT_W-1:0]     remain;
   logic                 cexp_evt;
   logic [7:0]           set_vec, clr_vec, flags;
   logic [7:0]           ien_q;
   logic [2:0]           mctl_q;
   logic [7:0]           pend, status_byte;
   logic                 any_pend;

   irq_reg_decode #(.ADDR_W(ADDR_W), .CNT_BYTES(CNT_BYTES)) u_dec (
      .wr_en    (host_wr),
      .wr_addr  (host_waddr),
      .clr_a_we (clr_a_we),
      .clr_b_we (clr_b_we),
      .ien_we   (ien_we),
      .mctl_we  (mctl_we),
      .cnt_we   (cnt_we)
   );

   irq_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_we  (cnt_we),
      .wdata    (host_wdata),
      .xfer_i   (xfer_pulse),
      .remain_o (remain),
      .expire_o (cexp_evt)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[FB_CEXP] = cexp_evt;
      set_vec[FB_WAIT] = wait_timeout;
      set_vec[FB_PTC]  = prim_tc;
      set_vec[FB_STC]  = sec_tc;
      clr_vec          = '0;
      clr_vec[FB_CEXP] = clr_b_we && host_wdata[CB_CEXP];
      clr_vec[FB_WAIT] = clr_a_we && host_wdata[CA_WAIT];
      clr_vec[FB_PTC]  = clr_a_we && host_wdata[CA_PTC];
      clr_vec[FB_STC]  = clr_a_we && host_wdata[CA_STC];
   end

   for (genvar i = 0; i < 8; i++) begin : g_flag
      if (STICKY_MASK[i]) begin : g_sticky
         irq_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .q_o   (flags[i])
         );
      end else if (i == FB_XRDY) begin : g_live
         assign flags[i] = fifo_not_empty;
      end else begin : g_none
         assign flags[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q  <= '0;
         mctl_q <= '0;
      end else begin
         if (ien_we)  ien_q  <= host_wdata & FLAG_MASK;
         if (mctl_we) mctl_q <= host_wdata[2:0];
      end
   end

   assign pend     = flags & ien_q;
   assign any_pend = |pend;
   assign irq_req  = any_pend && (mctl_q[1:0] != 2'b00);
   assign irq_line_sel = mctl_q[1:0];
   assign irq_open_out = mctl_q[2];

   always_comb begin
      status_byte          = '0;
      status_byte[ST_LEFT] = any_pend;
      status_byte[ST_REQ]  = req_line;
      status_byte[ST_STOP] = stop_trig;
   end

   always_comb begin
      host_rdata = '0;
      if (host_raddr == ADDR_W'(A_FLAG_CLRA))      host_rdata = flags;
      else if (host_raddr == ADDR_W'(A_STAT_CLRB)) host_rdata = status_byte;
      else if (host_raddr == ADDR_W'(A_IEN))       host_rdata = ien_q;
      else if (host_raddr == ADDR_W'(A_MCTL))      host_rdata = {5'b0, mctl_q};
      else begin
         for (int b = 0; b < CNT_BYTES; b++)
            if (host_raddr == ADDR_W'(A_CNT0 + b)) host_rdata = remain[b*8 +: 8];
      end
   end

   if (REG_STROBES) begin : g_reg_strobe
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fifo_reset <= 1'b0;
            dma_reset  <= 1'b0;
         end else begin
            fifo_reset <= clr_a_we && host_wdata[CA_FIFO];
            dma_reset  <= clr_a_we && host_wdata[CA_DMA];
         end
      end
      // R7: each strobe comes from a first-clear write one cycle earlier
      a_r7_fifo_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
         fifo_reset |-> $past(host_wr && host_waddr == ADDR_W'(A_FLAG_CLRA) && host_wdata[CA_FIFO]));
      a_r7_dma_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
         dma_reset |-> $past(host_wr && host_waddr == ADDR_W'(A_FLAG_CLRA) && host_wdata[CA_DMA]));
   end else begin : g_comb_strobe
      assign fifo_reset = clr_a_we && host_wdata[CA_FIFO];
      assign dma_reset  = clr_a_we && host_wdata[CA_DMA];
   end

   // R9: no line selected means no interrupt
   a_r9_no_line_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_line_sel == 2'b00) |-> !irq_req);
   // R10: data-left agrees with the interrupt when a line is selected
   a_r10_left_vs_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_line_sel != 2'b00) |-> (irq_req == host_rdata[ST_LEFT] || host_raddr != ADDR_W'(A_STAT_CLRB)));
   // R4: the first clear register leaves count expired alone
   a_r4_clra_keeps_cexp: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[FB_CEXP] && clr_a_we) |=> flags[FB_CEXP]);
endmodule

// File: tb/irq_flag_bank_tb.sv
`timescale 1ns/1ps
module irq_flag_bank_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [2:0] host_waddr = '0;
   logic [7:0] host_wdata = '0;
   logic [2:0] host_raddr = '0;
   logic [7:0] host_rdata;
   logic       fifo_not_empty = 1'b0, xfer_pulse = 1'b0, wait_timeout = 1'b0;
   logic       prim_tc = 1'b0, sec_tc = 1'b0, req_line = 1'b0, stop_trig = 1'b0;
   logic       irq_req, irq_open_out, fifo_reset, dma_reset;
   logic [1:0] irq_line_sel;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   irq_flag_bank u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_waddr(host_waddr),
      .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
      .fifo_not_empty(fifo_not_empty), .xfer_pulse(xfer_pulse),
      .wait_timeout(wait_timeout), .prim_tc(prim_tc), .sec_tc(sec_tc),
      .req_line(req_line), .stop_trig(stop_trig), .irq_req(irq_req),
      .irq_line_sel(irq_line_sel), .irq_open_out(irq_open_out),
      .fifo_reset(fifo_reset), .dma_reset(dma_reset)
   );

   // ---------------- reference model ----------------
   logic [7:0]  m_flag = '0;  // sticky bits only
   logic [7:0]  m_ien  = '0;
   logic [2:0]  m_mctl = '0;
   logic [31:0] m_rem  = '0;
   logic        m_fifo = 1'b0, m_dma = 1'b0;

   always @(posedge clk) begin
      logic [7:0] nf;
      logic       cntw, expire;
      if (!rst_n) begin
         m_flag = '0; m_ien = '0; m_mctl = '0; m_rem = '0; m_fifo = 0; m_dma = 0;
      end else begin
         cntw   = host_wr && host_waddr >= 3'd4;
         expire = xfer_pulse && !cntw && m_rem == 32'd1;
         nf = m_flag;
         if (host_wr && host_waddr == 3'd0) begin
            if (host_wdata[3]) nf[5] = 1'b0;
            if (host_wdata[4]) nf[6] = 1'b0;
            if (host_wdata[5]) nf[7] = 1'b0;
         end
         if (host_wr && host_waddr == 3'd1 && host_wdata[0]) nf[1] = 1'b0;
         if (expire)       nf[1] = 1'b1;
         if (wait_timeout) nf[5] = 1'b1;
         if (prim_tc)      nf[6] = 1'b1;
         if (sec_tc)       nf[7] = 1'b1;
         m_flag = nf;
         m_fifo = host_wr && host_waddr == 3'd0 && host_wdata[7];
         m_dma  = host_wr && host_waddr == 3'd0 && host_wdata[6];
         if (host_wr && host_waddr == 3'd2) m_ien = host_wdata & 8'hE3;
         if (host_wr && host_waddr == 3'd3) m_mctl = host_wdata[2:0];
         if (cntw) m_rem[(host_waddr-3'd4)*8 +: 8] = host_wdata;
         else if (xfer_pulse && m_rem != 0) m_rem = m_rem - 1;
      end
   end

   function automatic logic m_left();
      return |((m_flag | {7'b0, fifo_not_empty}) & m_ien);
   endfunction

   function automatic logic [7:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_flag | {7'b0, fifo_not_empty};
         3'd1: return {4'b0, stop_trig, req_line, 1'b0, m_left()};
         3'd2: return m_ien;
         3'd3: return {5'b0, m_mctl};
         default: return m_rem[(a-3'd4)*8 +: 8];
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] a);
      case (a)
         3'd0: return "R2";
         3'd1: return "R10";
         3'd2: return "R8";
         3'd3: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(host_rdata === m_read(host_raddr), req_of(host_raddr), "read data",
             host_rdata, m_read(host_raddr));
         chk(irq_req === (m_left() && m_mctl[1:0] != 0), "R9", "irq",
             irq_req, m_left() && m_mctl[1:0] != 0);
         chk(irq_line_sel === m_mctl[1:0] && irq_open_out === m_mctl[2], "R9",
             "line/open", {irq_open_out, irq_line_sel}, m_mctl);
         chk(fifo_reset === m_fifo && dma_reset === m_dma, "R7", "strobes",
             {fifo_reset, dma_reset}, {m_fifo, m_dma});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      host_wr = 1; host_waddr = a; host_wdata = d;
      @(posedge clk); #1;
      host_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      host_raddr = a; #1; v = host_rdata;
   endtask

   task automatic pulse(input logic x, input logic w, input logic p, input logic s);
      xfer_pulse = x; wait_timeout = w; prim_tc = p; sec_tc = s;
      @(posedge clk); #1;
      xfer_pulse = 0; wait_timeout = 0; prim_tc = 0; sec_tc = 0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5.0);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk(v == 8'h00, "R1", "reset read", v, 0);
      end
      chk(!irq_req && !fifo_reset && !dma_reset, "R1", "reset outputs",
          {irq_req, fifo_reset, dma_reset}, 0);
      // R3 live transfer ready
      fifo_not_empty = 1; rd(3'd0, v);
      chk(v == 8'h01, "R3", "xrdy high", v, 8'h01);
      fifo_not_empty = 0; rd(3'd0, v);
      chk(v == 8'h00, "R3", "xrdy low", v, 8'h00);
      // R2 sticky wait flag
      pulse(0, 1, 0, 0);
      repeat (3) @(posedge clk); #1;
      rd(3'd0, v);
      chk(v == 8'h20, "R2", "waited held", v, 8'h20);
      // R8 enable layout
      wr(3'd2, 8'hFF); rd(3'd2, v);
      chk(v == 8'hE3, "R8", "enable readback", v, 8'hE3);
      // R9 gating
      chk(irq_req == 0, "R9", "no line no irq", irq_req, 0);
      wr(3'd3, 8'h05);
      chk(irq_req == 1 && irq_line_sel == 2'd1 && irq_open_out == 1, "R9", "irq on",
          {irq_req, irq_open_out, irq_line_sel}, 4'b1101);
      // R10 status
      req_line = 1; stop_trig = 1; rd(3'd1, v);
      chk(v == 8'h0D, "R10", "status", v, 8'h0D);
      req_line = 0; stop_trig = 0;
      // R4 clear waited
      wr(3'd0, 8'h08); rd(3'd0, v);
      chk(v == 8'h00, "R4", "clear waited", v, 8'h00);
      // R11 count to expiry
      wr(3'd4, 8'h03); wr(3'd5, 8'h00); wr(3'd6, 8'h00); wr(3'd7, 8'h00);
      pulse(1, 0, 0, 0); pulse(1, 0, 0, 0); rd(3'd0, v);
      chk(v == 8'h00, "R11", "not yet expired", v, 8'h00);
      pulse(1, 0, 0, 0); rd(3'd0, v);
      chk(v == 8'h02, "R11", "expired", v, 8'h02);
      pulse(1, 0, 0, 0); rd(3'd4, v);
      chk(v == 8'h00, "R11", "stays zero", v, 8'h00);
      // R4 / R7 clear-all keeps count expired, strobes fire
      pulse(0, 1, 1, 1);
      wr(3'd0, 8'hF8);
      chk(fifo_reset && dma_reset, "R7", "strobes high", {fifo_reset, dma_reset}, 2'b11);
      rd(3'd0, v);
      chk(v == 8'h02, "R4", "F8 keeps cexp", v, 8'h02);
      @(posedge clk); #1;
      chk(!fifo_reset && !dma_reset, "R7", "strobes one cycle", {fifo_reset, dma_reset}, 0);
      // R5 second clear
      pulse(0, 0, 1, 0);
      wr(3'd1, 8'h00); rd(3'd0, v);
      chk(v == 8'h42, "R5", "bit0 zero no effect", v, 8'h42);
      wr(3'd1, 8'h01); rd(3'd0, v);
      chk(v == 8'h40, "R5", "cexp cleared only", v, 8'h40);
      // R6 collision
      prim_tc = 1; wr(3'd0, 8'h10); prim_tc = 0; rd(3'd0, v);
      chk(v == 8'h40, "R6", "set wins", v, 8'h40);
      // R11 multi-byte load and override
      wr(3'd4, 8'h34); wr(3'd5, 8'h12); rd(3'd5, v);
      chk(v == 8'h12, "R11", "byte1", v, 8'h12);
      xfer_pulse = 1; wr(3'd4, 8'h01); xfer_pulse = 0; rd(3'd4, v);
      chk(v == 8'h01, "R11", "write beats decrement", v, 8'h01);
      // R9 silence
      wr(3'd3, 8'h00);
      chk(irq_req == 0, "R9", "master zero silences", irq_req, 0);
      // random phase
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         fifo_not_empty = ($urandom_range(0, 3) == 0);
         req_line = $urandom_range(0, 1);
         stop_trig = $urandom_range(0, 1);
         xfer_pulse = ($urandom_range(0, 2) == 0);
         wait_timeout = ($urandom_range(0, 15) == 0);
         prim_tc = ($urandom_range(0, 15) == 0);
         sec_tc = ($urandom_range(0, 15) == 0);
         host_raddr = 3'($urandom_range(0, 7));
         host_wr = (r < 30);
         host_waddr = 3'($urandom_range(0, 7));
         host_wdata = 8'($urandom);
         if (host_waddr >= 3'd5) host_wdata = 8'h00;
         else if (host_waddr == 3'd4) host_wdata = 8'($urandom_range(0, 6));
         @(posedge clk); #1;
      end
      host_wr = 0; xfer_pulse = 0; wait_timeout = 0; prim_tc = 0; sec_tc = 0;
      @(posedge clk); #1;
      finish_run();
   end
endmodule